// File: doc/BRIEF.md
# PSK Subcarrier Modulator

This block turns a stream of data bits into a phase-shift-keyed square subcarrier. It produces one modulation level for each field-clock strobe. The carrier period can be 2, 4 or 8 samples, and each bit lasts a configurable number of samples. Each bit spans a whole number of carrier periods.

The block keeps a phase register. When a bit is accepted, its effective value (the data bit, complemented when the invert flag is set) is compared with that register. If the two differ, the bit begins with a reversal wave and the register toggles. If they match, the bit is made only of normal waves. A normal wave drives the phase value for its first half and the complement for its second half. The reversal wave has its halves swapped relative to the old phase, and normal waves then fill out the rest of the bit time.

Bits are taken through a valid/ready handshake. Bits follow each other with no idle samples between them. A frame-clear pulse returns the phase register to 0 between bits, and illegal settings are flagged.

Top module: `psk_subcarrier_mod`

## Requirements
- R1: After reset, `mod_level` is 0 and `cur_phase` is 0. `bit_ready` is 0 whenever `fc_strobe` is 0.
- R2: `bit_ready` is 1 exactly when `fc_strobe` is 1, no bit is in flight (or the previous bit's final sample has already been emitted), and `cfg_err` is 0. A bit is taken when `bit_valid` and `bit_ready` are both 1.
- R3: Let e be the effective value of the bit, C the carrier period and k the index of the sample within the bit (0 first). Sample k is e XOR ((k mod C) >= C/2). This holds for C = 2, 4 and 8.
- R4: A bit emits exactly `bit_len` samples, one per strobe. The strobe after its final sample can accept the next bit, so two bits sit back to back.
- R5: On acceptance, if e differs from `cur_phase`, then `cur_phase` toggles. Otherwise it is unchanged. `cur_phase` changes at no other time, except under R7.
- R6: The effective value e is `bit_data` XOR `bit_invert`.
- R7: `frame_clr` clears `cur_phase` when no bit is in flight. If it coincides with an acceptance, the comparison uses 0. If it arrives while a bit is in flight, it has no effect.
- R8: `cfg_err` is 1 when any of these holds: `carrier_len` is not 2, 4 or 8; `bit_len` is 0; `bit_len` is not a multiple of `carrier_len`. While `cfg_err` is 1, no bit is accepted.
- R9: A strobe with no bit in flight and none accepted emits level 0. Without a strobe, `mod_level` holds its value.
- R10: The carrier period and bit length are captured at acceptance. Changing the inputs during a bit does not alter that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_strobe | input | 1 | Field-clock strobe, one output sample per pulse |
| frame_clr | input | 1 | Clears the phase register at a frame start |
| bit_valid | input | 1 | Data bit offered |
| bit_ready | output | 1 | Data bit taken on this strobe |
| bit_data | input | 1 | Data bit |
| bit_invert | input | 1 | Complement the data bit before use |
| carrier_len | input | CAR_W | Carrier period in samples (2, 4 or 8) |
| bit_len | input | CNT_W | Bit period in samples |
| mod_level | output | 1 | Modulation level, updated on each strobe |
| cur_phase | output | 1 | Current carrier phase register |
| cfg_err | output | 1 | Illegal carrier period or bit length |

## Verification
Two functions can fall in the same cycle. A frame-clear pulse can arrive on the very strobe at which the next bit is accepted. A bit's final sample can also be followed on the next strobe by a fresh acceptance. The bench raises `frame_clr` together with an accepting strobe while the phase register holds 1. It judges the result by `cur_phase` and the first emitted level, both of which must follow the new bit. The bench also pulses `frame_clr` in the middle of a bit and expects the waveform and phase to be untouched. For back-to-back bits, it checks that `bit_ready` rises on the strobe right after the last sample and on no strobe before it.

// File: rtl/psk_pkg.sv
package psk_pkg;
  // Width of the carrier-period field
  localparam int PSK_CAR_W   = 4;
  // Largest carrier period is 2**PSK_MAX_LOG samples
  localparam int PSK_MAX_LOG = 3;

  // Second half of a carrier wave when the position reaches half the period
  function automatic logic in_second_half(input logic [PSK_CAR_W-1:0] pos,
                                          input logic [PSK_CAR_W-1:0] half);
    return (pos >= half);
  endfunction
endpackage

// File: rtl/psk_cfg_check.sv
module psk_cfg_check #(
  parameter int CNT_W   = 8,
  parameter int CAR_W   = psk_pkg::PSK_CAR_W,
  parameter int MAX_LOG = psk_pkg::PSK_MAX_LOG
) (
  input  logic [CAR_W-1:0] carrier_len,
  input  logic [CNT_W-1:0] bit_len,
  output logic             cfg_err
);
  logic [MAX_LOG:1] car_hit;
  logic [CAR_W-1:0] car_mask;
  logic             car_ok;
  logic             mult_ok;
  logic             len_ok;

  // One comparator per legal period 2, 4, ... 2**MAX_LOG
  for (genvar g = 1; g <= MAX_LOG; g++) begin : g_car
    assign car_hit[g] = (carrier_len == CAR_W'(1 << g));
  end

  assign car_ok   = |car_hit;
  assign car_mask = carrier_len - CAR_W'(1);

  always_comb begin
    mult_ok = ((bit_len & CNT_W'(car_mask)) == '0);
    len_ok  = (bit_len != '0);
    cfg_err = ~(car_ok & mult_ok & len_ok);
  end
endmodule

// File: rtl/psk_bit_seq.sv
module psk_bit_seq #(
  parameter int CNT_W = 8,
  parameter int CAR_W = psk_pkg::PSK_CAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_strobe,
  input  logic             accept,
  input  logic             frame_clr,
  input  logic             eff_bit,
  input  logic [CAR_W-1:0] carrier_len,
  input  logic [CNT_W-1:0] bit_len,
  output logic             busy,
  output logic [CAR_W-1:0] wave_pos,
  output logic [CAR_W-1:0] half_len,
  output logic             phase
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CAR_W-1:0] pos_q, pos_d;
  logic [CAR_W-1:0] car_q, car_d;
  logic             ph_q, ph_d;
  logic             ph_base;
  logic             reverse;
  logic             seq_en;

  assign busy     = (rem_q != '0);
  assign wave_pos = pos_q;
  assign half_len = car_q >> 1;
  assign phase    = ph_q;

  // Next-state logic
  always_comb begin
    rem_d   = rem_q;
    pos_d   = pos_q;
    car_d   = car_q;
    // A frame clear only counts between bits
    ph_base = (frame_clr && !busy) ? 1'b0 : ph_q;
    reverse = 1'b0;
    ph_d    = ph_base;
    if (accept) begin
      rem_d   = bit_len - CNT_W'(1);
      car_d   = carrier_len;
      pos_d   = CAR_W'(1) & (carrier_len - CAR_W'(1));
      reverse = eff_bit ^ ph_base;
      ph_d    = reverse ? ~ph_base : ph_base;
    end else if (fc_strobe && busy) begin
      rem_d = rem_q - CNT_W'(1);
      pos_d = (pos_q + CAR_W'(1)) & (car_q - CAR_W'(1));
    end
    seq_en = accept | (fc_strobe & busy) | frame_clr;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      pos_q <= '0;
      car_q <= CAR_W'(2);
      ph_q  <= 1'b0;
    end else if (seq_en) begin
      rem_q <= rem_d;
      pos_q <= pos_d;
      car_q <= car_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/psk_level_gen.sv
module psk_level_gen #(
  parameter int CAR_W = psk_pkg::PSK_CAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_strobe,
  input  logic             accept,
  input  logic             eff_bit,
  input  logic             busy,
  input  logic [CAR_W-1:0] wave_pos,
  input  logic [CAR_W-1:0] half_len,
  input  logic             phase,
  output logic             level
);
  logic lvl_q, lvl_d;

  assign level = lvl_q;

  // Sample selection
  always_comb begin
    if (accept) begin
      // First sample of a bit: first half of a wave at the new phase
      lvl_d = eff_bit;
    end else if (busy) begin
      lvl_d = phase ^ psk_pkg::in_second_half(wave_pos, half_len);
    end else begin
      lvl_d = 1'b0;
    end
  end

  // Output register, enabled by the field strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (fc_strobe) begin
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/psk_subcarrier_mod.sv
module psk_subcarrier_mod #(
  parameter int CNT_W = 8,
  parameter int CAR_W = psk_pkg::PSK_CAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_strobe,
  input  logic             frame_clr,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_data,
  input  logic             bit_invert,
  input  logic [CAR_W-1:0] carrier_len,
  input  logic [CNT_W-1:0] bit_len,
  output logic             mod_level,
  output logic             cur_phase,
  output logic             cfg_err
);
  logic             seq_busy;
  logic             accept;
  logic             eff_bit;
  logic [CAR_W-1:0] wave_pos;
  logic [CAR_W-1:0] half_len;

  assign eff_bit   = bit_data ^ bit_invert;
  assign bit_ready = fc_strobe & ~seq_busy & ~cfg_err;
  assign accept    = bit_valid & bit_ready;

  psk_cfg_check #(
    .CNT_W(CNT_W),
    .CAR_W(CAR_W)
  ) u_cfg (
    .carrier_len(carrier_len),
    .bit_len    (bit_len),
    .cfg_err    (cfg_err)
  );

  psk_bit_seq #(
    .CNT_W(CNT_W),
    .CAR_W(CAR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_strobe  (fc_strobe),
    .accept     (accept),
    .frame_clr  (frame_clr),
    .eff_bit    (eff_bit),
    .carrier_len(carrier_len),
    .bit_len    (bit_len),
    .busy       (seq_busy),
    .wave_pos   (wave_pos),
    .half_len   (half_len),
    .phase      (cur_phase)
  );

  psk_level_gen #(
    .CAR_W(CAR_W)
  ) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fc_strobe(fc_strobe),
    .accept   (accept),
    .eff_bit  (eff_bit),
    .busy     (seq_busy),
    .wave_pos (wave_pos),
    .half_len (half_len),
    .phase    (cur_phase),
    .level    (mod_level)
  );
endmodule

// File: rtl/psk_mod_checker.sv
module psk_mod_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fc_strobe,
  input logic             frame_clr,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic             bit_data,
  input logic             bit_invert,
  input logic [CNT_W-1:0] bit_len,
  input logic             mod_level,
  input logic             cur_phase,
  input logic             cfg_err,
  input logic             seq_busy
);
  logic             acc;
  logic [CNT_W-1:0] smp_cnt;
  logic [CNT_W-1:0] len_q;

  assign acc = bit_valid & bit_ready;

  // Independent count of samples emitted for the current bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt <= '0;
      len_q   <= '0;
    end else if (acc) begin
      smp_cnt <= CNT_W'(1);
      len_q   <= bit_len;
    end else if (fc_strobe && smp_cnt != '0) begin
      smp_cnt <= (smp_cnt == len_q) ? '0 : smp_cnt + CNT_W'(1);
    end
  end

  p_ready_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> (fc_strobe && !cfg_err));

  p_no_early_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_strobe && smp_cnt != '0 && smp_cnt < len_q) |-> !bit_ready);

  p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_strobe && smp_cnt != '0 && smp_cnt == len_q && !cfg_err) |-> bit_ready);

  p_first_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (mod_level == cur_phase));

  p_phase_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cur_phase == $past(bit_data ^ bit_invert)));

  p_phase_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !(frame_clr && !seq_busy)) |=> $stable(cur_phase));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_clr && !seq_busy && !acc) |=> !cur_phase);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_strobe |=> $stable(mod_level));
endmodule

bind psk_subcarrier_mod psk_mod_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/psk_subcarrier_mod_test.sv
`timescale 1ns/1ps
module psk_subcarrier_mod_test;
  logic       clk;
  logic       rst_n;
  logic       fc_strobe;
  logic       frame_clr;
  logic       bit_valid;
  logic       bit_ready;
  logic       bit_data;
  logic       bit_invert;
  logic [3:0] carrier_len;
  logic [7:0] bit_len;
  logic       mod_level;
  logic       cur_phase;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  psk_subcarrier_mod uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_strobe  (fc_strobe),
    .frame_clr  (frame_clr),
    .bit_valid  (bit_valid),
    .bit_ready  (bit_ready),
    .bit_data   (bit_data),
    .bit_invert (bit_invert),
    .carrier_len(carrier_len),
    .bit_len    (bit_len),
    .mod_level  (mod_level),
    .cur_phase  (cur_phase),
    .cfg_err    (cfg_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected level of sample k of a bit with effective value e
  function automatic logic exp_level(input logic e, input int k, input int car);
    return e ^ ((k % car) >= (car / 2));
  endfunction

  // Streams n bits (bits[0] first) and checks every sample and handshake
  task automatic run_stream(input logic [15:0] bits, input int n, input int car,
                            input int len, input logic inv, input int gap,
                            input string req);
    int   b   = 0;
    int   k   = 0;
    int   cyc = 0;
    logic prev;
    logic e;
    logic stb;
    carrier_len = 4'(car);
    bit_len     = 8'(len);
    bit_invert  = inv;
    prev        = mod_level;
    while (b < n) begin
      stb       = ((cyc % (gap + 1)) == 0);
      fc_strobe = stb;
      bit_valid = 1'b1;
      bit_data  = bits[b];
      #1;
      if (stb) chk(bit_ready == (k == 0), {req, " R2/R4 ready"}, int'(bit_ready), int'(k == 0));
      tick();
      if (stb) begin
        e = bits[b] ^ inv;
        chk(mod_level == exp_level(e, k, car), {req, " R3 level"},
            int'(mod_level), int'(exp_level(e, k, car)));
        if (k == 0) chk(cur_phase == e, {req, " R5 phase"}, int'(cur_phase), int'(e));
        k++;
        if (k == len) begin
          k = 0;
          b++;
        end
      end else begin
        chk(mod_level == prev, {req, " R9 hold"}, int'(mod_level), int'(prev));
      end
      prev = mod_level;
      cyc++;
    end
    bit_valid = 1'b0;
    fc_strobe = 1'b1;
    #1;
    chk(bit_ready == 1'b1, {req, " R4 ready after last"}, int'(bit_ready), 1);
    tick();
    chk(mod_level == 1'b0, {req, " R9 idle zero"}, int'(mod_level), 0);
    fc_strobe = 1'b0;
  endtask

  task automatic t_reset();
    carrier_len = 4'd2;
    bit_len     = 8'd2;
    rst_n       = 1'b0;
    repeat (3) tick();
    chk(mod_level == 1'b0, "R1 level", int'(mod_level), 0);
    chk(cur_phase == 1'b0, "R1 phase", int'(cur_phase), 0);
    chk(bit_ready == 1'b0, "R1 ready", int'(bit_ready), 0);
    rst_n = 1'b1;
    tick();
    chk(cfg_err == 1'b0, "R8 legal", int'(cfg_err), 0);
  endtask

  task automatic t_carriers();
    run_stream(16'b1101, 4, 2, 8, 1'b0, 0, "R3 car2");
    run_stream(16'b00110, 5, 4, 16, 1'b0, 2, "R3 car4");
    run_stream(16'b10011, 5, 8, 8, 1'b0, 1, "R3 car8");
    run_stream(16'b01, 2, 8, 24, 1'b0, 0, "R4 long");
  endtask

  task automatic t_invert();
    run_stream(16'b0110, 4, 4, 8, 1'b1, 0, "R6 invert");
  endtask

  task automatic t_cfg_err();
    frame_clr = 1'b1;
    tick();
    frame_clr = 1'b0;
    chk(cur_phase == 1'b0, "R7 clear idle", int'(cur_phase), 0);
    bit_data  = 1'b1;
    bit_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: begin carrier_len = 4'd6; bit_len = 8'd12; end
        1: begin carrier_len = 4'd4; bit_len = 8'd10; end
        2: begin carrier_len = 4'd2; bit_len = 8'd0;  end
        default: begin carrier_len = 4'd0; bit_len = 8'd8; end
      endcase
      fc_strobe = 1'b1;
      #1;
      chk(cfg_err == 1'b1, "R8 flag", int'(cfg_err), 1);
      chk(bit_ready == 1'b0, "R8 no ready", int'(bit_ready), 0);
      tick();
      chk(mod_level == 1'b0, "R8 bit ignored level", int'(mod_level), 0);
      chk(cur_phase == 1'b0, "R8 bit ignored phase", int'(cur_phase), 0);
    end
    fc_strobe   = 1'b0;
    bit_valid   = 1'b0;
    carrier_len = 4'd8;
    bit_len     = 8'd16;
    #1;
    chk(cfg_err == 1'b0, "R8 legal car8", int'(cfg_err), 0);
  endtask

  task automatic t_latch();
    carrier_len = 4'd4;
    bit_len     = 8'd8;
    bit_invert  = 1'b0;
    bit_data    = 1'b1;
    bit_valid   = 1'b1;
    fc_strobe   = 1'b1;
    tick();
    chk(mod_level == 1'b1, "R10 first", int'(mod_level), 1);
    bit_valid   = 1'b0;
    carrier_len = 4'd2;
    bit_len     = 8'd4;
    for (int k = 1; k < 8; k++) begin
      #1;
      chk(bit_ready == 1'b0, "R10 no early ready", int'(bit_ready), 0);
      tick();
      chk(mod_level == exp_level(1'b1, k, 4), "R10 latched",
          int'(mod_level), int'(exp_level(1'b1, k, 4)));
    end
    #1;
    chk(bit_ready == 1'b1, "R10 ready after 8", int'(bit_ready), 1);
    tick();
    fc_strobe = 1'b0;
  endtask

  task automatic t_frame_clr();
    // phase is 1 here; clear mid-bit must be ignored
    carrier_len = 4'd2;
    bit_len     = 8'd6;
    bit_invert  = 1'b0;
    bit_data    = 1'b1;
    bit_valid   = 1'b1;
    fc_strobe   = 1'b1;
    tick();
    bit_valid = 1'b0;
    for (int k = 1; k < 6; k++) begin
      frame_clr = (k == 2);
      tick();
      chk(mod_level == exp_level(1'b1, k, 2), "R7 mid-bit level",
          int'(mod_level), int'(exp_level(1'b1, k, 2)));
      chk(cur_phase == 1'b1, "R7 mid-bit phase kept", int'(cur_phase), 1);
    end
    // clear together with acceptance of a 1 while phase is 1
    frame_clr = 1'b1;
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    #1;
    chk(bit_ready == 1'b1, "R7 ready", int'(bit_ready), 1);
    tick();
    frame_clr = 1'b0;
    bit_valid = 1'b0;
    chk(cur_phase == 1'b1, "R7 same-cycle phase", int'(cur_phase), 1);
    chk(mod_level == 1'b1, "R7 same-cycle level", int'(mod_level), 1);
    repeat (5) tick();
    fc_strobe = 1'b0;
    tick();
    frame_clr = 1'b1;
    tick();
    frame_clr = 1'b0;
    chk(cur_phase == 1'b0, "R7 idle clear", int'(cur_phase), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    fc_strobe   = 1'b0;
    frame_clr   = 1'b0;
    bit_valid   = 1'b0;
    bit_data    = 1'b0;
    bit_invert  = 1'b0;
    carrier_len = 4'd2;
    bit_len     = 8'd2;
    @(negedge clk);
    t_reset();
    t_carriers();
    t_invert();
    t_cfg_err();
    t_latch();
    t_frame_clr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule